// File: doc/BRIEF.md
# Banked Memory Mapper with Programmable Common Region

This block sits between a processor with a 16-bit address bus and a 512 KB physical memory. It splits the 64 KB logical space at a programmable page boundary. Every logical page at or above the boundary belongs to the common region, which always lands in the physical copy of bank 0. Every page below the boundary belongs to the swappable window, which lands in the bank named by a 3-bit bank-select register. Bank 0 is the full 64 KB image used by the operating system. Banks 1 to 7 are user banks.

The boundary is counted in 256-byte pages. Software writes it once, early in start-up. After that first write it is frozen, so the memory layout cannot shift under running code. Some typical values:

| Boundary value | Common region | Banked window |
|---|---|---|
| 0xC0 | 16 KB | 48 KB |
| 0xB0 | 20 KB | 44 KB |
| 0x80 | 32 KB | 32 KB (one-bit bank switch) |

The bank-select register can be rewritten at any time. Both registers share one write port: a write strobe, a select line and a data byte. The translation path itself has no register in it.

Top module: `bank_mapper`

## Requirements
- R1: `phys_addr[15:0]` always equals `cpu_addr`.
- R2: When `cpu_addr[15:8]` is greater than or equal to the boundary register, `phys_addr[18:16]` is 0.
- R3: When `cpu_addr[15:8]` is below the boundary register, `phys_addr[18:16]` equals the bank register.
- R4: The first write with `cfg_sel`=1 loads `cfg_wdata` into the boundary register. Every later boundary write is ignored until reset.
- R5: `bound_locked` goes to 1 on the clock edge of the first boundary write. It stays at 1 until reset.
- R6: A write with `cfg_sel`=0 loads `cfg_wdata[2:0]` into the bank register at any time. The new bank appears in `phys_addr` only after that clock edge. In the cycle of the write, the old bank is still used.
- R7: After reset, the boundary register is 0x00, so the whole space is common. The bank register is 0 and `bound_locked` is 0.
- R8: A boundary of 0x80 gives a 32 KB / 32 KB split. Address 0x7FFF is banked and address 0x8000 is common.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_addr | input | 16 | Logical address from the processor |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = bank register, 1 = boundary register |
| cfg_wdata | input | 8 | Write data |
| phys_addr | output | 19 | Physical address: {bank, logical address} |
| bound_locked | output | 1 | Boundary register has been written and is frozen |

## Verification
Two things can happen in the same cycle: a bank-select write and a processor access to the swappable window. The bench provokes this by driving the write strobe and a banked address together. It then checks that `phys_addr` carries the old bank before the edge and the new bank after it. The boundary lock meets another write in the same way. A second boundary write is placed right after the first. It is judged by probing addresses on both sides of the old and the attempted boundary.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  parameter int unsigned LOG_W  = 16;
  parameter int unsigned PAGE_W = 8;
  parameter int unsigned BANK_W = 3;
  localparam int unsigned PHYS_W = BANK_W + LOG_W;

  typedef enum logic {
    SEL_BANK  = 1'b0,
    SEL_BOUND = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/mapper_rst_sync.sv
module mapper_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mapper_cfg_regs.sv
module mapper_cfg_regs
  import mapper_pkg::*;
#(
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned BW = BANK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          sel,
  input  logic [PW-1:0] wdata,
  output logic [BW-1:0] bank_q,
  output logic [PW-1:0] bound_q,
  output logic          lock_q
);
  logic          ld_bank, ld_bound;
  logic [BW-1:0] bank_d;
  logic [PW-1:0] bound_d;
  logic          lock_d;

  // next-state
  always_comb begin
    ld_bank  = wr_en && (cfg_sel_e'(sel) == SEL_BANK);
    ld_bound = wr_en && (cfg_sel_e'(sel) == SEL_BOUND) && !lock_q;
    bank_d   = wdata[BW-1:0];
    bound_d  = wdata;
    lock_d   = 1'b1;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      bound_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (ld_bank)  bank_q  <= bank_d;
      if (ld_bound) bound_q <= bound_d;
      if (ld_bound) lock_q  <= lock_d;
    end
  end
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import mapper_pkg::*;
#(
  parameter int unsigned LW = LOG_W,
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned BW = BANK_W,
  localparam int unsigned OW = BW + LW
) (
  input  logic [LW-1:0] log_addr,
  input  logic [BW-1:0] bank,
  input  logic [PW-1:0] bound,
  output logic [OW-1:0] phys
);
  logic [PW-1:0] page;
  logic          in_common;

  always_comb begin
    page      = log_addr[LW-1 -: PW];
    in_common = (page >= bound);
    phys      = {(in_common ? {BW{1'b0}} : bank), log_addr};
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  cpu_addr,
  input  logic              cfg_wr_en,
  input  logic              cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              bound_locked
);
  logic              rst_sync_n;
  logic [BANK_W-1:0] bank_q;
  logic [PAGE_W-1:0] bound_q;

  mapper_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mapper_cfg_regs regs_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr_en), .sel(cfg_sel),
    .wdata(cfg_wdata), .bank_q(bank_q), .bound_q(bound_q), .lock_q(bound_locked)
  );

  mapper_xlate xlate_i (
    .log_addr(cpu_addr), .bank(bank_q), .bound(bound_q), .phys(phys_addr)
  );
endmodule

// File: rtl/mapper_chk.sv
module mapper_chk
  import mapper_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [LOG_W-1:0]  cpu_addr,
  input logic              cfg_wr_en,
  input logic              cfg_sel,
  input logic [PAGE_W-1:0] cfg_wdata,
  input logic [PHYS_W-1:0] phys_addr,
  input logic              bound_locked,
  input logic [BANK_W-1:0] bank_q,
  input logic [PAGE_W-1:0] bound_q
);
  assert_addr_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[LOG_W-1:0] == cpu_addr);

  assert_common_bank0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[LOG_W-1 -: PAGE_W] >= bound_q) |-> (phys_addr[PHYS_W-1 -: BANK_W] == '0));

  assert_window_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[LOG_W-1 -: PAGE_W] < bound_q) |-> (phys_addr[PHYS_W-1 -: BANK_W] == bank_q));

  assert_first_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_sel && !bound_locked) |=> (bound_q == $past(cfg_wdata)));

  assert_bound_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bound_locked |=> $stable(bound_q));

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bound_locked |=> bound_locked);

  assert_lock_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_sel) |=> bound_locked);

  assert_bank_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_sel) |=> (bank_q == $past(cfg_wdata[BANK_W-1:0])));
endmodule

bind bank_mapper mapper_chk chk_i (
  .clk(clk), .rst_n(rst_sync_n), .cpu_addr(cpu_addr), .cfg_wr_en(cfg_wr_en),
  .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .phys_addr(phys_addr),
  .bound_locked(bound_locked), .bank_q(bank_q), .bound_q(bound_q)
);

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cfg_wr_en;
  logic        cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [18:0] phys_addr;
  logic        bound_locked;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cfg_wr_en(cfg_wr_en),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .phys_addr(phys_addr),
    .bound_locked(bound_locked)
  );

  // {bank[2:0], addr[15:0], expected phys[18:0]} with boundary 0xC0
  localparam int NVEC = 8;
  localparam logic [37:0] VEC [NVEC] = '{
    {3'd3, 16'h0000, 19'h30000},
    {3'd3, 16'hBFFF, 19'h3BFFF},
    {3'd3, 16'hC000, 19'h0C000},
    {3'd7, 16'h1234, 19'h71234},
    {3'd7, 16'hFFFF, 19'h0FFFF},
    {3'd1, 16'h8000, 19'h18000},
    {3'd0, 16'h4000, 19'h04000},
    {3'd5, 16'hBF00, 19'h5BF00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; cpu_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [15:0] a, input logic [18:0] exp);
    cpu_addr = a;
    #1;
    check(tag, 32'(phys_addr), 32'(exp));
  endtask

  initial begin
    do_reset();
    // R7: reset state
    check("R7 lock", 32'(bound_locked), 32'd0);
    probe("R7", 16'h5A5A, 19'h05A5A);
    wr(1'b0, 8'd6);
    probe("R7 all common", 16'h0100, 19'h00100);
    probe("R1", 16'hA5C3, 19'h0A5C3);

    // R4/R5: first boundary write locks
    wr(1'b1, 8'hC0);
    check("R5 lock", 32'(bound_locked), 32'd1);
    wr(1'b0, 8'd3);
    wr(1'b1, 8'h40);
    probe("R4 ignored", 16'h8000, 19'h38000);
    probe("R4 boundary", 16'hC000, 19'h0C000);
    check("R5 sticky", 32'(bound_locked), 32'd1);

    // vector walk, boundary 0xC0
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b0, {5'd0, VEC[i][37:35]});
      probe((VEC[i][34:19] >= 16'hC000) ? "R2" : "R3", VEC[i][34:19], VEC[i][18:0]);
    end

    // R6: bank write in the same cycle as a banked access
    wr(1'b0, 8'd2);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'd5; cpu_addr = 16'h1000;
    #1;
    check("R6 old bank", 32'(phys_addr), 32'h21000);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1;
    check("R6 new bank", 32'(phys_addr), 32'h51000);

    // R8: 32/32 split
    do_reset();
    check("R7 lock after reset", 32'(bound_locked), 32'd0);
    wr(1'b1, 8'h80);
    wr(1'b0, 8'd1);
    probe("R8 banked", 16'h7FFF, 19'h17FFF);
    probe("R8 common", 16'h8000, 19'h08000);

    // 20K/44K split
    do_reset();
    wr(1'b1, 8'hB0);
    wr(1'b0, 8'd2);
    probe("R3 20k", 16'hAFFF, 19'h2AFFF);
    probe("R2 20k", 16'hB000, 19'h0B000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule